// File: doc/BRIEF.md
# Compatibility-Mode Sensitive Opcode Trap Checker

This block sits beside the decode stage of a processor that can run legacy 16-bit code inside a protected compatibility mode. Each cycle the decoder can offer the leading opcode byte of an instruction. It can also offer the byte that follows, which a software interrupt uses as its vector number. Along with these come the compatibility-mode bit taken from bit 17 of the flags register, the two-bit I/O privilege level and the mode-extension enable from bit 0 of control register 4. The block sorts the opcode into a class. It then decides whether the instruction must trap to the supervisor with a general protection fault.

The decision is registered. One cycle after an accepted request, a result valid strobe comes out together with the fault flag, the fault vector, the error code and the interrupt number. A saturating counter records how many faults have been raised since reset, so the supervisor can see how often the guest code traps.

Top module: `v86_trap_checker`

## Requirements
- R1: While reset is asserted and on the first cycle after it, out_valid, out_fault and fault_count are all 0.
- R2: out_valid is high in exactly the cycle after a cycle with in_valid high. out_fault is never high while out_valid is low.
- R3: When mode_v86 is 0, no opcode raises a fault.
- R4: In compatibility mode with iopl below 3, each of the flag-sensitive opcodes faults: 0xFA (clear interrupt flag), 0xFB (set interrupt flag), 0x9C (push flags), 0x9D (pop flags) and 0xCF (interrupt return).
- R5: In compatibility mode with iopl equal to 3, the five flag-sensitive opcodes of R4 do not fault.
- R6: In compatibility mode, opcode 0xCD (software interrupt) faults at every iopl value, including 3, when vme_en is 0. It does not fault when vme_en is 1.
- R7: In compatibility mode, opcode 0xF4 (halt) always faults, whatever the values of iopl and vme_en.
- R8: A faulting result carries out_vector 13 and out_errcode 0. A result that does not fault carries out_vector 0.
- R9: On a result for opcode 0xCD, out_int_num equals the second opcode byte. On any other result it is 0.
- R10: Opcodes outside the set {0xFA, 0xFB, 0x9C, 0x9D, 0xCF, 0xCD, 0xF4} never fault.
- R11: fault_count rises by one in the cycle each fault result appears. It holds at 2^CNT_W-1 once it reaches that value, and it is otherwise unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe; the inputs below are sampled when it is high |
| op_byte0 | input | 8 | Leading opcode byte |
| op_byte1 | input | 8 | Following byte (interrupt number for 0xCD) |
| mode_v86 | input | 1 | Compatibility-mode bit (flags bit 17) |
| iopl | input | 2 | I/O privilege level |
| vme_en | input | 1 | Mode-extension enable (control register 4 bit 0) |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_fault | output | 1 | The instruction must trap |
| out_vector | output | 8 | Fault vector (13 on a fault) |
| out_errcode | output | ERR_W | Error code pushed with the fault (0) |
| out_int_num | output | 8 | Interrupt number for a software interrupt |
| fault_count | output | CNT_W | Saturating count of raised faults |

## Verification
The bench covers four corner cases. The first is the software interrupt at full privilege: a design that merged it with the flag-sensitive class would let it through when vme_en is 0. The second is halt at privilege 3 with the extension on: a design that applied privilege to every opcode would miss that trap. The third is every trapping opcode with the mode bit cleared, which catches a design that forgets to gate the decision on mode. The fourth is the fault counter driven past its maximum, which shows whether it wraps to zero instead of holding. Back-to-back requests check that the valid strobe and the result fields keep to their own request when nothing sits idle between them.

// File: rtl/v86_trap_pkg.sv
package v86_trap_pkg;

    // Opcode classes recognised by the checker
    typedef enum logic [1:0] {
        CLS_PLAIN     = 2'd0,  // not privilege sensitive
        CLS_FLAG_SENS = 2'd1,  // allowed only at full I/O privilege
        CLS_SWINT     = 2'd2,  // software interrupt, needs the extension
        CLS_HALT      = 2'd3   // always trapped in compatibility mode
    } op_class_e;

    localparam logic [7:0] OPC_CLR_IF  = 8'hFA;
    localparam logic [7:0] OPC_SET_IF  = 8'hFB;
    localparam logic [7:0] OPC_PUSH_FL = 8'h9C;
    localparam logic [7:0] OPC_POP_FL  = 8'h9D;
    localparam logic [7:0] OPC_INT_RET = 8'hCF;
    localparam logic [7:0] OPC_SW_INT  = 8'hCD;
    localparam logic [7:0] OPC_HALT    = 8'hF4;

    localparam logic [7:0] GP_FAULT_VEC = 8'd13;
    localparam logic [1:0] IOPL_FULL    = 2'd3;

endpackage

// File: rtl/v86_op_classify.sv
module v86_op_classify
    import v86_trap_pkg::*;
(
    input  logic [7:0] opcode,
    output op_class_e  op_class
);

    always_comb begin
        unique case (opcode)
            OPC_CLR_IF,
            OPC_SET_IF,
            OPC_PUSH_FL,
            OPC_POP_FL,
            OPC_INT_RET: op_class = CLS_FLAG_SENS;
            OPC_SW_INT:  op_class = CLS_SWINT;
            OPC_HALT:    op_class = CLS_HALT;
            default:     op_class = CLS_PLAIN;
        endcase
    end

endmodule

// File: rtl/v86_trap_policy.sv
module v86_trap_policy
    import v86_trap_pkg::*;
(
    input  op_class_e  op_class,
    input  logic       mode_v86,
    input  logic [1:0] iopl,
    input  logic       vme_en,
    output logic       trap
);

    logic full_priv;

    always_comb begin
        full_priv = (iopl == IOPL_FULL);
        trap      = 1'b0;
        if (mode_v86) begin
            unique case (op_class)
                CLS_FLAG_SENS: trap = !full_priv;
                CLS_SWINT:     trap = !vme_en;
                CLS_HALT:      trap = 1'b1;
                default:       trap = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/v86_fault_counter.sv
module v86_fault_counter #(
    parameter int CNT_W    = 4,
    parameter bit SATURATE = 1'b1
) (
    input  logic [CNT_W-1:0] count_q,
    input  logic             inc,
    output logic [CNT_W-1:0] count_d
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    generate
        if (SATURATE) begin : g_sat
            always_comb begin
                count_d = count_q;
                if (inc && (count_q != CNT_MAX)) begin
                    count_d = count_q + 1'b1;
                end
            end
        end else begin : g_wrap
            always_comb begin
                count_d = count_q;
                if (inc) begin
                    count_d = count_q + 1'b1;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/v86_trap_checker.sv
module v86_trap_checker
    import v86_trap_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int ERR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       op_byte0,
    input  logic [7:0]       op_byte1,
    input  logic             mode_v86,
    input  logic [1:0]       iopl,
    input  logic             vme_en,
    output logic             out_valid,
    output logic             out_fault,
    output logic [7:0]       out_vector,
    output logic [ERR_W-1:0] out_errcode,
    output logic [7:0]       out_int_num,
    output logic [CNT_W-1:0] fault_count
);

    localparam logic [ERR_W-1:0] GP_ERR_CODE = '0;

    typedef struct packed {
        logic             valid;
        logic             fault;
        logic [7:0]       vector;
        logic [ERR_W-1:0] err;
        logic [7:0]       int_num;
        logic [CNT_W-1:0] count;
    } state_t;

    state_t    st_d, st_q;
    op_class_e cls;
    logic      trap;
    logic      fault_now;
    logic [CNT_W-1:0] count_next;

    v86_op_classify u_classify (
        .opcode   (op_byte0),
        .op_class (cls)
    );

    v86_trap_policy u_policy (
        .op_class (cls),
        .mode_v86 (mode_v86),
        .iopl     (iopl),
        .vme_en   (vme_en),
        .trap     (trap)
    );

    v86_fault_counter #(
        .CNT_W    (CNT_W),
        .SATURATE (1'b1)
    ) u_counter (
        .count_q (st_q.count),
        .inc     (fault_now),
        .count_d (count_next)
    );

    always_comb begin
        fault_now    = in_valid && trap;
        st_d         = st_q;
        st_d.valid   = in_valid;
        st_d.fault   = fault_now;
        st_d.vector  = fault_now ? GP_FAULT_VEC : 8'd0;
        st_d.err     = GP_ERR_CODE;
        st_d.int_num = (in_valid && (cls == CLS_SWINT)) ? op_byte1 : 8'd0;
        st_d.count   = count_next;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid   = st_q.valid;
    assign out_fault   = st_q.fault;
    assign out_vector  = st_q.vector;
    assign out_errcode = st_q.err;
    assign out_int_num = st_q.int_num;
    assign fault_count = st_q.count;

endmodule

// File: rtl/v86_trap_checker_sva.sv
module v86_trap_checker_sva #(
    parameter int CNT_W = 4,
    parameter int ERR_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [7:0]       op_byte0,
    input logic [7:0]       op_byte1,
    input logic             mode_v86,
    input logic [1:0]       iopl,
    input logic             vme_en,
    input logic             out_valid,
    input logic             out_fault,
    input logic [7:0]       out_vector,
    input logic [ERR_W-1:0] out_errcode,
    input logic [7:0]       out_int_num,
    input logic [CNT_W-1:0] fault_count
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic flag_sens;
    assign flag_sens = (op_byte0 == 8'hFA) || (op_byte0 == 8'hFB) ||
                       (op_byte0 == 8'h9C) || (op_byte0 == 8'h9D) ||
                       (op_byte0 == 8'hCF);

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_fault_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_fault |-> out_valid);
    assert_mode_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mode_v86) |=> !out_fault);
    assert_low_priv_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode_v86 && flag_sens && (iopl != 2'd3)) |=> out_fault);
    assert_full_priv_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode_v86 && flag_sens && (iopl == 2'd3)) |=> !out_fault);
    assert_swint_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode_v86 && (op_byte0 == 8'hCD)) |=> (out_fault == !$past(vme_en)));
    assert_halt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode_v86 && (op_byte0 == 8'hF4)) |=> out_fault);
    assert_fault_vec_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_fault |-> ((out_vector == 8'd13) && (out_errcode == '0)));
    assert_int_num_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op_byte0 == 8'hCD)) |=> (out_int_num == $past(op_byte1)));
    assert_count_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_fault && ($past(fault_count) != CNT_MAX)) |-> (fault_count == $past(fault_count) + 1'b1));
    assert_count_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !out_fault |-> $stable(fault_count));

endmodule

bind v86_trap_checker v86_trap_checker_sva #(
    .CNT_W (CNT_W),
    .ERR_W (ERR_W)
) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .op_byte0    (op_byte0),
    .op_byte1    (op_byte1),
    .mode_v86    (mode_v86),
    .iopl        (iopl),
    .vme_en      (vme_en),
    .out_valid   (out_valid),
    .out_fault   (out_fault),
    .out_vector  (out_vector),
    .out_errcode (out_errcode),
    .out_int_num (out_int_num),
    .fault_count (fault_count)
);

// File: tb/test_v86_trap_checker.sv
`timescale 1ns/1ps
module test_v86_trap_checker;

    localparam int CNT_W = 4;
    localparam int ERR_W = 32;
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [7:0]       op_byte0 = 8'h00;
    logic [7:0]       op_byte1 = 8'h00;
    logic             mode_v86 = 1'b0;
    logic [1:0]       iopl = 2'd0;
    logic             vme_en = 1'b0;
    logic             out_valid;
    logic             out_fault;
    logic [7:0]       out_vector;
    logic [ERR_W-1:0] out_errcode;
    logic [7:0]       out_int_num;
    logic [CNT_W-1:0] fault_count;

    int n_checks = 0;
    int n_fail   = 0;
    logic [CNT_W-1:0] exp_cnt = '0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    v86_trap_checker #(.CNT_W(CNT_W), .ERR_W(ERR_W)) i_v86_trap_checker (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .op_byte0(op_byte0), .op_byte1(op_byte1), .mode_v86(mode_v86),
        .iopl(iopl), .vme_en(vme_en), .out_valid(out_valid),
        .out_fault(out_fault), .out_vector(out_vector),
        .out_errcode(out_errcode), .out_int_num(out_int_num),
        .fault_count(fault_count)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Independent model of the trap rule
    function automatic bit model_trap(input logic [7:0] op, input logic m,
                                      input logic [1:0] pl, input logic ve);
        if (!m) return 1'b0;
        case (op)
            8'hFA, 8'hFB, 8'h9C, 8'h9D, 8'hCF: return (pl != 2'd3);
            8'hCD: return !ve;
            8'hF4: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic drive(input logic [7:0] b0, input logic [7:0] b1, input logic m,
                         input logic [1:0] pl, input logic ve);
        in_valid = 1'b1; op_byte0 = b0; op_byte1 = b1;
        mode_v86 = m; iopl = pl; vme_en = ve;
    endtask

    task automatic check_result(input string req, input logic [7:0] b0, input logic [7:0] b1,
                                input logic m, input logic [1:0] pl, input logic ve);
        bit e;
        e = model_trap(b0, m, pl, ve);
        if (e && exp_cnt != CMAX) exp_cnt = exp_cnt + 1'b1;
        check(out_valid == 1'b1, "R2", out_valid, 1);
        check(out_fault == e, req, out_fault, e);
        check(out_vector == (e ? 8'd13 : 8'd0), "R8", out_vector, e ? 13 : 0);
        if (e) check(out_errcode == '0, "R8", out_errcode, 0);
        check(out_int_num == ((b0 == 8'hCD) ? b1 : 8'd0), "R9", out_int_num,
              (b0 == 8'hCD) ? b1 : 0);
        check(fault_count == exp_cnt, "R11", fault_count, exp_cnt);
    endtask

    // One request, result checked one cycle later, then idle checked
    task automatic send(input string req, input logic [7:0] b0, input logic [7:0] b1,
                        input logic m, input logic [1:0] pl, input logic ve);
        @(negedge clk);
        drive(b0, b1, m, pl, ve);
        @(negedge clk);
        in_valid = 1'b0;
        check_result(req, b0, b1, m, pl, ve);
        @(negedge clk);
        check(out_valid == 1'b0 && out_fault == 1'b0, "R2", {out_valid, out_fault}, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1", out_valid, 0);
        check(out_fault == 1'b0, "R1", out_fault, 0);
        check(fault_count == '0, "R1", fault_count, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0 && fault_count == '0, "R1", {out_valid, fault_count}, 0);
        exp_cnt = '0;
    endtask

    task automatic t_mode_off();
        logic [7:0] ops [7] = '{8'hFA, 8'hFB, 8'h9C, 8'h9D, 8'hCF, 8'hCD, 8'hF4};
        foreach (ops[i]) send("R3", ops[i], 8'h21, 1'b0, 2'd0, 1'b0);
    endtask

    task automatic t_low_priv();
        logic [7:0] ops [5] = '{8'hFA, 8'hFB, 8'h9C, 8'h9D, 8'hCF};
        for (int pl = 0; pl < 3; pl++)
            foreach (ops[i]) send("R4", ops[i], 8'h00, 1'b1, pl[1:0], 1'b0);
    endtask

    task automatic t_full_priv();
        logic [7:0] ops [5] = '{8'hFA, 8'hFB, 8'h9C, 8'h9D, 8'hCF};
        foreach (ops[i]) send("R5", ops[i], 8'h00, 1'b1, 2'd3, 1'b1);
        foreach (ops[i]) send("R5", ops[i], 8'h00, 1'b1, 2'd3, 1'b0);
    endtask

    task automatic t_swint();
        send("R6", 8'hCD, 8'h10, 1'b1, 2'd3, 1'b0);
        send("R6", 8'hCD, 8'h21, 1'b1, 2'd0, 1'b0);
        send("R6", 8'hCD, 8'h10, 1'b1, 2'd3, 1'b1);
        send("R6", 8'hCD, 8'hFF, 1'b1, 2'd1, 1'b1);
        send("R9", 8'hFA, 8'h55, 1'b1, 2'd3, 1'b0);
    endtask

    task automatic t_halt();
        for (int pl = 0; pl < 4; pl++) begin
            send("R7", 8'hF4, 8'h00, 1'b1, pl[1:0], 1'b1);
            send("R7", 8'hF4, 8'h00, 1'b1, pl[1:0], 1'b0);
        end
    endtask

    task automatic t_other();
        logic [7:0] ops [6] = '{8'h90, 8'hE4, 8'hEC, 8'hCC, 8'hCE, 8'h00};
        foreach (ops[i]) send("R10", ops[i], 8'h33, 1'b1, 2'd0, 1'b0);
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        drive(8'hFA, 8'h00, 1'b1, 2'd0, 1'b0);
        @(negedge clk);
        check_result("R4", 8'hFA, 8'h00, 1'b1, 2'd0, 1'b0);
        drive(8'hCD, 8'h13, 1'b1, 2'd3, 1'b1);
        @(negedge clk);
        check_result("R6", 8'hCD, 8'h13, 1'b1, 2'd3, 1'b1);
        drive(8'hF4, 8'h00, 1'b1, 2'd3, 1'b1);
        @(negedge clk);
        in_valid = 1'b0;
        check_result("R7", 8'hF4, 8'h00, 1'b1, 2'd3, 1'b1);
        @(negedge clk);
        check(out_valid == 1'b0, "R2", out_valid, 0);
    endtask

    task automatic t_saturate();
        for (int k = 0; k < 20; k++) send("R11", 8'hF4, 8'h00, 1'b1, 2'd0, 1'b0);
        check(fault_count == CMAX, "R11", fault_count, CMAX);
        send("R11", 8'h90, 8'h00, 1'b1, 2'd0, 1'b0);
        check(fault_count == CMAX, "R11", fault_count, CMAX);
    endtask

    initial begin
        t_reset();
        t_mode_off();
        t_low_priv();
        t_full_priv();
        t_swint();
        t_halt();
        t_other();
        t_back_to_back();
        t_saturate();
        t_reset();
        send("R11", 8'hFB, 8'h00, 1'b1, 2'd2, 1'b0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule